// File: doc/BRIEF.md
# Parallel-Compare Cache Tag Unit

This block is the tag store of a fully associative cache. It holds one tag and one valid bit per line and compares the incoming line address against every stored tag in the same cycle. On an access it reports hit or miss and the matching line index, both derived combinationally from the current address. It supports a plain access (read or write), an access that discards the line afterwards, and a replace command. Tags, valid bits and usage order change only at the rising clock edge, and every command takes one cycle.

Line usage is tracked as a least-recently-used order. The unit always presents the line that the next replace will overwrite, together with the tag that line currently holds, so a cache controller can start a write-back before it issues the replace. Invalid lines are kept at the least-recently-used end of the order. As a result, they are always chosen as victims before any valid line. The data array and the write-back path sit outside this block.

Top module: `ctag_unit`

## Requirements
- R1: After a synchronous active-high reset, every line is invalid, the usage order is line index order, the victim index is 0 and the victim tag is 0.
- R2: With req_i and repl_i both low, hit_o and miss_o are low and no tag, valid bit or usage order changes.
- R3: While req_i is high, hit_o is high and miss_o low in the same cycle exactly when a valid line's tag equals addr_i. hit_line_o then gives that line, and the lowest-numbered line wins if several match. Otherwise miss_o is high and hit_o low. Invalid lines never match.
- R4: An access with inv_i low (wr_i 0 = read, wr_i 1 = write) that hits moves the hit line to most-recently-used at the clock edge. Its tag and valid bit are kept.
- R5: An access with inv_i high that hits clears the line's valid bit and moves the line to least-recently-used, so it becomes the victim in the next cycle. This holds for both values of wr_i.
- R6: An access that misses changes no state, whatever the values of wr_i and inv_i.
- R7: With repl_i high and req_i low, the victim line receives addr_i as its tag, becomes valid and becomes most-recently-used at the clock edge.
- R8: victim_line_o always shows the least-recently-used line, and victim_tag_o shows the tag stored in that line. Whenever some line is invalid, the victim is an invalid line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| repl_i | input | 1 | Replace the victim line with addr_i |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | Access kind: 0 read, 1 write |
| inv_i | input | 1 | Discard the line after this access |
| addr_i | input | ADDR_W | Line address used for lookup and replace |
| hit_line_o | output | IDX_W | Line index of the matching tag |
| hit_o | output | 1 | Address found in a valid line (during req_i) |
| miss_o | output | 1 | Address not found (during req_i) |
| victim_line_o | output | IDX_W | Line the next replace will overwrite |
| victim_tag_o | output | ADDR_W | Tag currently stored in the victim line |

## Verification
The hardest situation to reach is a usage order in which invalid and valid lines are interleaved in history, because a discarded line has to jump ahead of lines that were used long before it, and later replaces have to consume these holes before any valid line. The bench first fills a small four-line unit, discards lines that sit in the middle of the order, and then refills them. After that it runs a long pseudo-random mix of reads, writes, discarding accesses, misses and replaces over an address space four times the line count. A model of the tags, valid bits and order is kept in the bench, and every output is compared with it in every cycle. Address sweeps across all sixteen values give the full hit and miss picture at several points.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE    = 2'd0,
    CMD_ACCESS  = 2'd1,
    CMD_DISCARD = 2'd2,
    CMD_REPLACE = 2'd3
  } ctag_cmd_e;

  function automatic ctag_cmd_e ctag_decode(input logic req, input logic inv,
                                            input logic repl);
    if (req && !repl) return inv ? CMD_DISCARD : CMD_ACCESS;
    if (repl && !req) return CMD_REPLACE;
    return CMD_IDLE;
  endfunction
endpackage

// File: rtl/ctag_match.sv
module ctag_match #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0][ADDR_W-1:0] tags_i,
  input  logic [LINES-1:0]             valid_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic                         any_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [LINES-1:0] eq;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tags_i[g] == addr_i);
  end

  assign any_o = |eq;

  // lowest matching line wins
  always_comb begin
    idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ctag_lru.sv
module ctag_lru #(
  parameter int LINES = 32,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en_i,
  input  logic [IDX_W-1:0] touch_line_i,
  input  logic             to_front_i,
  output logic [IDX_W-1:0] victim_o
);
  // slot 0 = least recently used, slot LINES-1 = most recently used
  logic [LINES-1:0][IDX_W-1:0] ord_q;
  logic [LINES-1:0][IDX_W-1:0] back_v;
  logic [LINES-1:0][IDX_W-1:0] front_v;
  logic [IDX_W-1:0]            pos;

  always_comb begin
    pos = '0;
    for (int i = 0; i < LINES; i++) begin
      if (ord_q[i] == touch_line_i) pos = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_slot
    if (g == LINES - 1) begin : g_top
      assign back_v[g] = touch_line_i;
    end else begin : g_mid
      assign back_v[g] = (IDX_W'(g) < pos) ? ord_q[g] : ord_q[g+1];
    end
    if (g == 0) begin : g_bot
      assign front_v[g] = touch_line_i;
    end else begin : g_up
      assign front_v[g] = (IDX_W'(g) <= pos) ? ord_q[g-1] : ord_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) ord_q[i] <= IDX_W'(i);
    end else if (touch_en_i) begin
      ord_q <= to_front_i ? front_v : back_v;
    end
  end

  assign victim_o = ord_q[0];
endmodule

// File: rtl/ctag_unit.sv
module ctag_unit #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              repl_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              inv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  hit_line_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [IDX_W-1:0]  victim_line_o,
  output logic [ADDR_W-1:0] victim_tag_o
);
  import ctag_pkg::*;

  logic [LINES-1:0][ADDR_W-1:0] tag_q;
  logic [LINES-1:0]             valid_q;
  logic                         found;
  logic [IDX_W-1:0]             found_idx;
  logic [IDX_W-1:0]             victim;
  ctag_cmd_e                    cmd;
  logic                         touch_en;
  logic [IDX_W-1:0]             touch_line;
  logic                         wr_unused;

  assign cmd       = ctag_decode(req_i, inv_i, repl_i);
  assign wr_unused = wr_i; // read and write touch the tags identically

  ctag_match #(.LINES(LINES), .ADDR_W(ADDR_W)) u_match (
    .tags_i (tag_q),
    .valid_i(valid_q),
    .addr_i (addr_i),
    .any_o  (found),
    .idx_o  (found_idx)
  );

  assign touch_en   = (cmd == CMD_REPLACE) ||
                      (found && (cmd == CMD_ACCESS || cmd == CMD_DISCARD));
  assign touch_line = (cmd == CMD_REPLACE) ? victim : found_idx;

  ctag_lru #(.LINES(LINES)) u_lru (
    .clk         (clk),
    .rst         (rst),
    .touch_en_i  (touch_en),
    .touch_line_i(touch_line),
    .to_front_i  (cmd == CMD_DISCARD),
    .victim_o    (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q   <= '0;
      valid_q <= '0;
    end else begin
      case (cmd)
        CMD_REPLACE: begin
          tag_q[victim]   <= addr_i;
          valid_q[victim] <= 1'b1;
        end
        CMD_DISCARD: if (found) valid_q[found_idx] <= 1'b0;
        default: ;
      endcase
    end
  end

  assign hit_o         = req_i && found;
  assign miss_o        = req_i && !found;
  assign hit_line_o    = found_idx;
  assign victim_line_o = victim;
  assign victim_tag_o  = tag_q[victim];
endmodule

// File: rtl/ctag_unit_chk.sv
module ctag_unit_chk #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              repl_i,
  input logic              req_i,
  input logic              inv_i,
  input logic [IDX_W-1:0]  hit_line_o,
  input logic              hit_o,
  input logic              miss_o,
  input logic [IDX_W-1:0]  victim_line_o,
  input logic [ADDR_W-1:0] victim_tag_o,
  input logic [LINES-1:0]  valid_q
);
  assert_reset_victim_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> victim_line_o == '0);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_i |-> !hit_o && !miss_o);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !req_i && !repl_i |=> $stable(victim_line_o) && $stable(victim_tag_o));

  assert_hit_xor_miss_R3: assert property (@(posedge clk) disable iff (rst)
    req_i |-> (hit_o ^ miss_o));

  assert_discard_victim_R5: assert property (@(posedge clk) disable iff (rst)
    req_i && !repl_i && inv_i && hit_o |=> victim_line_o == $past(hit_line_o));

  assert_miss_hold_R6: assert property (@(posedge clk) disable iff (rst)
    req_i && !repl_i && miss_o |=> $stable(victim_line_o) && $stable(victim_tag_o));

  assert_replace_moves_R7: assert property (@(posedge clk) disable iff (rst)
    repl_i && !req_i && (LINES > 1) |=> victim_line_o != $past(victim_line_o));

  assert_invalid_first_R8: assert property (@(posedge clk) disable iff (rst)
    !(&valid_q) |-> !valid_q[victim_line_o]);
endmodule

bind ctag_unit ctag_unit_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .repl_i       (repl_i),
  .req_i        (req_i),
  .inv_i        (inv_i),
  .hit_line_o   (hit_line_o),
  .hit_o        (hit_o),
  .miss_o       (miss_o),
  .victim_line_o(victim_line_o),
  .victim_tag_o (victim_tag_o),
  .valid_q      (valid_q)
);

// File: tb/ctag_unit_bench.sv
`timescale 1ns/1ps
module ctag_unit_bench;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          repl_i = 1'b0, req_i = 1'b0, wr_i = 1'b0, inv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [IW-1:0] hit_line_o, victim_line_o;
  logic          hit_o, miss_o;
  logic [AW-1:0] victim_tag_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  int mtag [N];
  bit mval [N];
  int mord [N];

  always #10 clk = ~clk;

  ctag_unit #(.LINES(N), .ADDR_W(AW)) u_ctag_unit (
    .clk(clk), .rst(rst), .repl_i(repl_i), .req_i(req_i), .wr_i(wr_i),
    .inv_i(inv_i), .addr_i(addr_i), .hit_line_o(hit_line_o), .hit_o(hit_o),
    .miss_o(miss_o), .victim_line_o(victim_line_o), .victim_tag_o(victim_tag_o)
  );

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int mfind(input int a);
    for (int i = 0; i < N; i++) if (mval[i] && mtag[i] == a) return i;
    return -1;
  endfunction

  function automatic int mpos(input int ln);
    for (int i = 0; i < N; i++) if (mord[i] == ln) return i;
    return 0;
  endfunction

  task automatic m_back(input int ln);
    int p = mpos(ln);
    for (int i = p; i < N - 1; i++) mord[i] = mord[i+1];
    mord[N-1] = ln;
  endtask

  task automatic m_front(input int ln);
    int p = mpos(ln);
    for (int i = p; i > 0; i--) mord[i] = mord[i-1];
    mord[0] = ln;
  endtask

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin mtag[i] = 0; mval[i] = 0; mord[i] = i; end
  endtask

  // drive one cycle, check combinational and state outputs, then update model
  task automatic cyc(input bit rq, input bit wr, input bit iv, input bit rp,
                     input int a, input string tagname);
    int h;
    @(negedge clk);
    req_i = rq; wr_i = wr; inv_i = iv; repl_i = rp; addr_i = AW'(a);
    #3;
    h = mfind(a);
    if (rq) begin
      check({tagname, " hit"}, int'(hit_o), int'(h >= 0));
      check({tagname, " miss"}, int'(miss_o), int'(h < 0));
      if (h >= 0) check({"R3 hit_line"}, int'(hit_line_o), h);
    end else begin
      check("R2 hit low", int'(hit_o), 0);
      check("R2 miss low", int'(miss_o), 0);
    end
    check("R8 victim line", int'(victim_line_o), mord[0]);
    check("R8 victim tag", int'(victim_tag_o), mtag[mord[0]]);
    begin : inv_first
      bit any_inv = 1'b0;
      for (int i = 0; i < N; i++) if (!mval[i]) any_inv = 1'b1;
      if (any_inv) check("R8 invalid victim", int'(mval[victim_line_o]), 0);
    end
    @(posedge clk);
    if (rp && !rq) begin
      int v = mord[0];
      mtag[v] = a; mval[v] = 1'b1; m_back(v);
    end else if (rq && h >= 0) begin
      if (iv) begin mval[h] = 1'b0; m_front(h); end
      else m_back(h);
    end
  endtask

  task automatic sweep(input string tagname);
    for (int a = 0; a < (1 << AW); a++) cyc(1'b1, a[0], 1'b0, 1'b0, a, tagname);
  endtask

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #3;
    check("R1 victim after reset", int'(victim_line_o), 0);
    check("R1 victim tag after reset", int'(victim_tag_o), 0);

    cyc(0, 0, 0, 0, 5, "R2");
    cyc(0, 1, 1, 0, 9, "R2");
    sweep("R1 empty sweep");

    // fill: R7
    cyc(0, 0, 0, 1, 3, "R7");
    cyc(0, 0, 0, 1, 7, "R7");
    cyc(0, 0, 0, 1, 11, "R7");
    cyc(0, 0, 0, 1, 14, "R7");
    sweep("R3 full sweep");

    // R4 read and write hits reorder
    cyc(1, 0, 0, 0, 3, "R4");
    cyc(1, 1, 0, 0, 11, "R4");
    // R6 misses of every kind
    cyc(1, 0, 0, 0, 2, "R6");
    cyc(1, 1, 0, 0, 2, "R6");
    cyc(1, 0, 1, 0, 2, "R6");
    cyc(1, 1, 1, 0, 2, "R6");
    // R5 discard middle-of-order lines, both access kinds
    cyc(1, 0, 1, 0, 14, "R5");
    cyc(1, 1, 1, 0, 3, "R5");
    cyc(1, 0, 0, 0, 14, "R5 gone");
    // refill holes
    cyc(0, 0, 0, 1, 0, "R7");
    cyc(0, 0, 0, 1, 15, "R7");
    cyc(0, 0, 0, 1, 8, "R7");
    sweep("R3 refill sweep");

    // pseudo-random mix
    begin : rnd
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[2:0] == 3'd0)
          cyc(0, 0, 0, 1, int'(lf[7:4]), "R7 rnd");
        else if (lf[2:0] == 3'd1)
          cyc(0, lf[8], lf[9], 0, int'(lf[7:4]), "R2 rnd");
        else
          cyc(1, lf[8], (lf[11:10] == 2'b00), 0, int'(lf[7:4]), "R3 rnd");
      end
    end
    sweep("R3 final sweep");

    // reset again mid-use
    @(negedge clk); rst = 1'b1;
    @(posedge clk); m_reset();
    @(negedge clk); rst = 1'b0;
    #3;
    check("R1 victim after reset", int'(victim_line_o), 0);
    sweep("R1 post reset sweep");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule